// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block sits behind a CAN receiver's deserialiser. It decides which received frames are kept. Each incoming frame header arrives with a one-cycle strobe. The header carries a 29-bit identifier field, an extended-format flag and a remote-request flag. The header is packed into a fixed filter word layout. It is then compared in parallel against every filter slot in the bank.

Each slot holds two 32-bit words and four control bits:
- a width bit selects one wide comparison or two narrow ones;
- a type bit selects masked compare or exact list;
- a routing bit picks one of two receive queues;
- an enable bit gates the slot.

One clock after the strobe, the block reports three things: whether the frame was kept, the queue it goes to, and the lowest-numbered slot that matched.

Software configures the bank through a write-only port. It first sets a global configuration flag. It then disables a slot, rewrites that slot's words and control bits, re-enables the slot, and clears the flag. While the flag is set, no frame is accepted.

Top module: `can_acc_filter_bank`

## Requirements
- R1: Each cycle, `res_valid` equals the previous cycle's `hdr_valid`. When `res_hit` is 0, `res_fifo` and `res_idx` are 0.
- R2: The header is packed as wide word {std[31:21], ext[20:3], ide[2], rtr[1], 1'b0} and narrow half {std[15:5], ide[4], rtr[3], ext[17:15] at [2:0]}.
  - A standard frame (ide=0) uses id[10:0] as std and zero as ext.
  - An extended frame uses id[28:18] as std and id[17:0] as ext.
- R3: Wide width, mask type: the slot matches when every packed bit whose bit in word B is 1 equals the same bit of word A.
- R4: Wide width, list type: the slot matches when the packed word equals word A or word B exactly.
- R5: Narrow width, mask type: each word is one narrow filter, with bits [15:0] as the pattern and bits [31:16] as the mask. The slot matches if either word matches the narrow half.
- R6: Narrow width, list type: the slot matches when the narrow half equals any of A[15:0], A[31:16], B[15:0] or B[31:16].
- R7: A slot whose enable bit is 0 never matches.
- R8: When several slots match, the lowest index is reported.
- R9: `res_fifo` is the routing bit of the winning slot (0 = queue 0, 1 = queue 1).
- R10: While the configuration flag is 1, `res_hit` is 0.
- R11: Writes to a slot's width, type or routing bit, or to its words, are ignored unless the configuration flag is 1 and that slot's enable bit is 0. Enable bits are writable at any time.
- R12: Register map (write port):
  - address 0, bit 0: configuration flag;
  - address 1: enable bits;
  - address 2: width bits (1 = wide);
  - address 3: type bits (1 = list);
  - address 4: routing bits;
  - address 8+2i: word A of slot i;
  - address 9+2i: word B of slot i.
  
  Bit i of addresses 1 to 4 belongs to slot i. Other addresses are ignored. After reset, every register is zero, so no frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |
| hdr_valid | input | 1 | Frame header strobe |
| hdr_id | input | 29 | Identifier (low 11 bits used for standard frames) |
| hdr_ide | input | 1 | Extended-format flag |
| hdr_rtr | input | 1 | Remote-request flag |
| res_valid | output | 1 | Result strobe, one cycle after `hdr_valid` |
| res_hit | output | 1 | Frame accepted |
| res_fifo | output | 1 | Receive queue select |
| res_idx | output | IDX_W | Index of the winning slot |

## Verification
The bound checker verifies the cycle-level invariants on every clock:
- the result strobe follows the header strobe one cycle later;
- a miss drives zero queue and index outputs;
- an accepted frame names a slot that was enabled and in range, and carries that slot's routing bit;
- nothing is accepted during configuration;
- width, type and routing bits stay stable outside configuration and for enabled slots.

The packing of standard and extended headers, the four comparison variants, lowest-index priority and the silent dropping of locked word writes involve the stored filter words. Only the bench's reference model, fed with directed and random headers, can show those.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  // Register map (write port)
  localparam int CTRL_ADDR  = 0;
  localparam int ACT_ADDR   = 1;
  localparam int SCALE_ADDR = 2;
  localparam int MODE_ADDR  = 3;
  localparam int ROUTE_ADDR = 4;
  localparam int BANK_BASE  = 8;

  localparam int ID_W   = 29;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic [10:0] std_id;
    logic [17:0] ext_id;
    logic        ide;
    logic        rtr;
    logic        pad;
  } wide_word_t;

  typedef struct packed {
    logic [10:0] std_id;
    logic        ide;
    logic        rtr;
    logic [2:0]  ext_hi;
  } narrow_word_t;

  function automatic wide_word_t pack_wide(input logic [ID_W-1:0] id,
                                           input logic ide, input logic rtr);
    wide_word_t w;
    w.std_id = ide ? id[28:18] : id[10:0];
    w.ext_id = ide ? id[17:0]  : 18'd0;
    w.ide    = ide;
    w.rtr    = rtr;
    w.pad    = 1'b0;
    return w;
  endfunction

  function automatic narrow_word_t pack_narrow(input wide_word_t w);
    narrow_word_t n;
    n.std_id = w.std_id;
    n.ide    = w.ide;
    n.rtr    = w.rtr;
    n.ext_hi = w.ext_id[17:15];
    return n;
  endfunction

endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
#(
  parameter int NUM_FILT = 14,
  parameter int ADDR_W   = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [ADDR_W-1:0]                cfg_addr,
  input  logic [WORD_W-1:0]                cfg_wdata,
  output logic                             init_o,
  output logic [NUM_FILT-1:0]              act_o,
  output logic [NUM_FILT-1:0]              scale_o,
  output logic [NUM_FILT-1:0]              mode_o,
  output logic [NUM_FILT-1:0]              route_o,
  output logic [NUM_FILT-1:0][WORD_W-1:0]  word_a_o,
  output logic [NUM_FILT-1:0][WORD_W-1:0]  word_b_o
);

  logic                init_q, init_d;
  logic [NUM_FILT-1:0] act_q, act_d;
  logic [NUM_FILT-1:0] scale_q, scale_d;
  logic [NUM_FILT-1:0] mode_q, mode_d;
  logic [NUM_FILT-1:0] route_q, route_d;
  logic [NUM_FILT-1:0] wr_data_bits;
  logic [NUM_FILT-1:0] open_mask;

  assign wr_data_bits = cfg_wdata[NUM_FILT-1:0];
  // Slots that may be rewritten this cycle
  assign open_mask    = init_q ? ~act_q : '0;

  always_comb begin
    init_d  = init_q;
    act_d   = act_q;
    scale_d = scale_q;
    mode_d  = mode_q;
    route_d = route_q;
    if (cfg_we) begin
      case (cfg_addr)
        ADDR_W'(CTRL_ADDR):  init_d  = cfg_wdata[0];
        ADDR_W'(ACT_ADDR):   act_d   = wr_data_bits;
        ADDR_W'(SCALE_ADDR): scale_d = (scale_q & ~open_mask) | (wr_data_bits & open_mask);
        ADDR_W'(MODE_ADDR):  mode_d  = (mode_q  & ~open_mask) | (wr_data_bits & open_mask);
        ADDR_W'(ROUTE_ADDR): route_d = (route_q & ~open_mask) | (wr_data_bits & open_mask);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      act_q   <= '0;
      scale_q <= '0;
      mode_q  <= '0;
      route_q <= '0;
    end else begin
      init_q  <= init_d;
      act_q   <= act_d;
      scale_q <= scale_d;
      mode_q  <= mode_d;
      route_q <= route_d;
    end
  end

  for (genvar gi = 0; gi < NUM_FILT; gi++) begin : g_words
    logic [WORD_W-1:0] a_q, b_q;
    logic              a_en, b_en;

    assign a_en = cfg_we && open_mask[gi] && (cfg_addr == ADDR_W'(BANK_BASE + 2*gi));
    assign b_en = cfg_we && open_mask[gi] && (cfg_addr == ADDR_W'(BANK_BASE + 2*gi + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
      end else begin
        if (a_en) a_q <= cfg_wdata;
        if (b_en) b_q <= cfg_wdata;
      end
    end

    assign word_a_o[gi] = a_q;
    assign word_b_o[gi] = b_q;
  end

  assign init_o  = init_q;
  assign act_o   = act_q;
  assign scale_o = scale_q;
  assign mode_o  = mode_q;
  assign route_o = route_q;

endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
  import can_filt_pkg::*;
(
  input  logic [WORD_W-1:0] key_wide,
  input  logic [HALF_W-1:0] key_narrow,
  input  logic              enable,
  input  logic              wide,
  input  logic              list,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              hit
);

  logic wide_mask_hit, wide_list_hit;
  logic nar_mask_hit, nar_list_hit;
  logic [HALF_W-1:0] halves [4];

  assign halves[0] = word_a[HALF_W-1:0];
  assign halves[1] = word_a[WORD_W-1:HALF_W];
  assign halves[2] = word_b[HALF_W-1:0];
  assign halves[3] = word_b[WORD_W-1:HALF_W];

  // Wide: A = pattern, B = care bits
  assign wide_mask_hit = ((key_wide ^ word_a) & word_b) == '0;
  assign wide_list_hit = (key_wide == word_a) || (key_wide == word_b);

  // Narrow mask: each word = {care, pattern}
  assign nar_mask_hit = (((key_narrow ^ halves[0]) & halves[1]) == '0) ||
                        (((key_narrow ^ halves[2]) & halves[3]) == '0);

  always_comb begin
    nar_list_hit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (key_narrow == halves[k]) nar_list_hit = 1'b1;
    end
  end

  always_comb begin
    if (!enable)   hit = 1'b0;
    else if (wide) hit = list ? wide_list_hit : wide_mask_hit;
    else           hit = list ? nar_list_hit  : nar_mask_hit;
  end

endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int NUM_FILT = 14,
  parameter int IDX_W    = 4
) (
  input  logic [NUM_FILT-1:0] hits,
  output logic                any_hit,
  output logic [IDX_W-1:0]    win_idx
);

  // Scan downward so the lowest index is the last assignment
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = NUM_FILT - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/can_acc_filter_bank.sv
module can_acc_filter_bank
  import can_filt_pkg::*;
#(
  parameter  int NUM_FILT = 14,   // at most 32: one enable bit per data bit
  localparam int ADDR_W   = $clog2(BANK_BASE + 2*NUM_FILT),
  localparam int IDX_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              hdr_valid,
  input  logic [28:0]       hdr_id,
  input  logic              hdr_ide,
  input  logic              hdr_rtr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_fifo,
  output logic [IDX_W-1:0]  res_idx
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic                            init_q;
  logic [NUM_FILT-1:0]             act_q, scale_q, mode_q, route_q;
  logic [NUM_FILT-1:0][WORD_W-1:0] word_a, word_b;

  can_filt_cfg #(.NUM_FILT(NUM_FILT), .ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .init_o   (init_q),
    .act_o    (act_q),
    .scale_o  (scale_q),
    .mode_o   (mode_q),
    .route_o  (route_q),
    .word_a_o (word_a),
    .word_b_o (word_b)
  );

  wide_word_t   key_w;
  narrow_word_t key_n;
  assign key_w = pack_wide(hdr_id, hdr_ide, hdr_rtr);
  assign key_n = pack_narrow(key_w);

  logic [NUM_FILT-1:0] slot_hit;
  for (genvar gi = 0; gi < NUM_FILT; gi++) begin : g_slot
    can_filt_match u_match (
      .key_wide  (key_w),
      .key_narrow(key_n),
      .enable    (act_q[gi]),
      .wide      (scale_q[gi]),
      .list      (mode_q[gi]),
      .word_a    (word_a[gi]),
      .word_b    (word_b[gi]),
      .hit       (slot_hit[gi])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  can_filt_prio #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_prio (
    .hits   (slot_hit),
    .any_hit(any_hit),
    .win_idx(win_idx)
  );

  // Result stage
  logic             valid_d, hit_d, fifo_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    valid_d = hdr_valid;
    hit_d   = hdr_valid && any_hit && !init_q;
    fifo_d  = 1'b0;
    idx_d   = '0;
    if (hit_d) begin
      fifo_d = route_q[win_idx];
      idx_d  = win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fifo  <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= valid_d;
      res_hit   <= hit_d;
      res_fifo  <= fifo_d;
      res_idx   <= idx_d;
    end
  end

endmodule

// File: rtl/can_filt_bank_chk.sv
module can_filt_bank_chk #(
  parameter int NUM_FILT = 14,
  parameter int IDX_W    = 4
) (
  input logic                clk,
  input logic                rst_n_s,
  input logic                hdr_valid,
  input logic                init_q,
  input logic [NUM_FILT-1:0] act_q,
  input logic [NUM_FILT-1:0] scale_q,
  input logic [NUM_FILT-1:0] mode_q,
  input logic [NUM_FILT-1:0] route_q,
  input logic                res_valid,
  input logic                res_hit,
  input logic                res_fifo,
  input logic [IDX_W-1:0]    res_idx
);

  logic [NUM_FILT-1:0] act_prev, route_prev, scale_prev, mode_prev;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      act_prev   <= '0;
      route_prev <= '0;
      scale_prev <= '0;
      mode_prev  <= '0;
    end else begin
      act_prev   <= act_q;
      route_prev <= route_q;
      scale_prev <= scale_q;
      mode_prev  <= mode_q;
    end
  end

  AST_RESULT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n_s)
    hdr_valid |=> res_valid); // R1
  AST_NO_STROBE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n_s)
    !hdr_valid |=> !res_valid); // R1
  AST_MISS_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    !res_hit |-> (!res_fifo && res_idx == '0)); // R1
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_hit |-> res_valid); // R1
  AST_HIT_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_hit |-> act_prev[res_idx]); // R7
  AST_HIT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_hit |-> (int'(res_idx) < NUM_FILT)); // R8
  AST_HIT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_hit |-> (res_fifo == route_prev[res_idx])); // R9
  AST_INIT_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n_s)
    init_q |=> !res_hit); // R10
  AST_CTRL_LOCKED_RUN: assert property (@(posedge clk) disable iff (!rst_n_s)
    !init_q |=> ($stable(scale_q) && $stable(mode_q) && $stable(route_q))); // R11
  AST_CTRL_LOCKED_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (((scale_q ^ scale_prev) | (mode_q ^ mode_prev) | (route_q ^ route_prev)) & act_prev) == '0); // R11

endmodule

bind can_acc_filter_bank can_filt_bank_chk #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .hdr_valid(hdr_valid),
  .init_q   (init_q),
  .act_q    (act_q),
  .scale_q  (scale_q),
  .mode_q   (mode_q),
  .route_q  (route_q),
  .res_valid(res_valid),
  .res_hit  (res_hit),
  .res_fifo (res_fifo),
  .res_idx  (res_idx)
);

// File: tb/can_acc_filter_bank_test.sv
`timescale 1ns/1ps
module can_acc_filter_bank_test;

  localparam int NF = 14;
  localparam int AW = 6;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [31:0]   cfg_wdata;
  logic          hdr_valid;
  logic [28:0]   hdr_id;
  logic          hdr_ide;
  logic          hdr_rtr;
  logic          res_valid, res_hit, res_fifo;
  logic [IW-1:0] res_idx;

  always #4 clk = ~clk;  // 125 MHz

  can_acc_filter_bank uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .hdr_id(hdr_id),
    .hdr_ide(hdr_ide), .hdr_rtr(hdr_rtr), .res_valid(res_valid),
    .res_hit(res_hit), .res_fifo(res_fifo), .res_idx(res_idx)
  );

  // Reference model state
  logic [31:0] m_a [NF];
  logic [31:0] m_b [NF];
  logic [NF-1:0] m_act, m_scale, m_mode, m_route;
  logic m_init;
  logic e_valid, e_hit, e_fifo;
  int   e_idx;
  int   n_checks = 0;
  int   n_fail   = 0;
  string cur_req = "R12";

  function automatic logic [31:0] wpack(input logic [28:0] id, input logic ide, input logic rtr);
    logic [10:0] s;
    logic [17:0] e;
    s = ide ? id[28:18] : id[10:0];
    e = ide ? id[17:0] : 18'd0;
    return {s, e, ide, rtr, 1'b0};
  endfunction

  function automatic logic [15:0] npack(input logic [28:0] id, input logic ide, input logic rtr);
    logic [31:0] w;
    w = wpack(id, ide, rtr);
    return {w[31:21], ide, rtr, w[20:18]};
  endfunction

  function automatic logic slot_ok(input int i, input logic [31:0] w, input logic [15:0] h);
    logic [15:0] q [4];
    if (!m_act[i]) return 1'b0;
    if (m_scale[i]) begin
      if (m_mode[i]) return (w == m_a[i]) || (w == m_b[i]);
      return ((w ^ m_a[i]) & m_b[i]) == 0;
    end
    q[0] = m_a[i][15:0]; q[1] = m_a[i][31:16];
    q[2] = m_b[i][15:0]; q[3] = m_b[i][31:16];
    if (m_mode[i]) return (h == q[0]) || (h == q[1]) || (h == q[2]) || (h == q[3]);
    return (((h ^ q[0]) & q[1]) == 0) || (((h ^ q[2]) & q[3]) == 0);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // One clock: check outputs, drive inputs, predict, update model
  task automatic step(input logic we, input int addr, input logic [31:0] d,
                      input logic hv, input logic [28:0] id, input logic ide, input logic rtr);
    logic [31:0] w;
    logic [15:0] h;
    int k;
    n_checks++;
    if (res_valid !== e_valid || res_hit !== e_hit || res_fifo !== e_fifo || int'(res_idx) != e_idx) begin
      n_fail++;
      $display("FAIL %s: got v=%0b hit=%0b fifo=%0b idx=%0d, expected v=%0b hit=%0b fifo=%0b idx=%0d",
               cur_req, res_valid, res_hit, res_fifo, res_idx, e_valid, e_hit, e_fifo, e_idx);
    end
    cfg_we = we; cfg_addr = AW'(addr); cfg_wdata = d;
    hdr_valid = hv; hdr_id = id; hdr_ide = ide; hdr_rtr = rtr;
    e_valid = hv; e_hit = 1'b0; e_fifo = 1'b0; e_idx = 0;
    if (hv && !m_init) begin
      w = wpack(id, ide, rtr);
      h = npack(id, ide, rtr);
      k = 0;
      while (k < NF && !e_hit) begin
        if (slot_ok(k, w, h)) begin
          e_hit = 1'b1; e_idx = k; e_fifo = m_route[k];
        end
        k++;
      end
    end
    if (we) begin
      if (addr == 0) m_init = d[0];
      else if (addr == 1) m_act = d[NF-1:0];
      else if (addr >= 2 && addr <= 4) begin
        for (int i = 0; i < NF; i++) begin
          if (m_init && !m_act[i]) begin
            if (addr == 2) m_scale[i] = d[i];
            if (addr == 3) m_mode[i]  = d[i];
            if (addr == 4) m_route[i] = d[i];
          end
        end
      end else if (addr >= 8 && addr < 8 + 2*NF) begin
        if (m_init && !m_act[(addr-8)/2]) begin
          if (addr % 2 == 0) m_a[(addr-8)/2] = d;
          else               m_b[(addr-8)/2] = d;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();                                  step(0, 0, 0, 0, 0, 0, 0);   endtask
  task automatic wr(input int a, input logic [31:0] d);  step(1, a, d, 0, 0, 0, 0);   endtask
  task automatic hd(input logic [28:0] id, input logic ide, input logic rtr);
    step(0, 0, 0, 1, id, ide, rtr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] n0, n1, n2, n3, nm;
    for (int i = 0; i < NF; i++) begin m_a[i] = 0; m_b[i] = 0; end
    m_act = 0; m_scale = 0; m_mode = 0; m_route = 0; m_init = 0;
    e_valid = 0; e_hit = 0; e_fifo = 0; e_idx = 0;
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    hdr_valid = 0; hdr_id = 0; hdr_ide = 0; hdr_rtr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state, nothing accepted
    cur_req = "R12";
    repeat (4) idle();
    hd(29'h21, 0, 0);
    hd(29'h1234567, 1, 0);
    idle();
    wr(0, 1);
    wr(5, 32'hFFFF_FFFF);   // R12: unmapped address ignored
    wr(7, 32'hFFFF_FFFF);
    // slot 0: wide mask, low 7 std bits = 0x21
    wr(8, 32'h21 << 21);  wr(9, 32'h7F << 21);
    // slot 1: wide list
    wr(10, wpack(29'h080, 0, 0));  wr(11, wpack(29'h12345678, 1, 0));
    // slot 2: narrow mask, std=0x300 and ide=0 in both words
    nm = {11'h7FF, 1'b1, 1'b0, 3'b000};
    wr(12, {nm, npack(29'h300, 0, 0)});  wr(13, {nm, npack(29'h300, 0, 0)});
    // slot 3: narrow list
    n0 = npack(29'h011, 0, 1); n1 = npack(29'h012, 0, 0);
    n2 = npack(29'h1A2C0000, 1, 0); n3 = npack(29'h013, 0, 0);
    wr(14, {n1, n0});  wr(15, {n3, n2});
    // slot 4: any extended frame; slot 5: copy of slot 0
    wr(16, 32'h4);  wr(17, 32'h4);
    wr(18, 32'h21 << 21);  wr(19, 32'h7F << 21);
    wr(2, 32'h33); wr(3, 32'h0A); wr(4, 32'h30);
    wr(1, 32'h3F);
    cur_req = "R10";
    hd(29'h21, 0, 0);  hd(29'h080, 0, 0);  hd(29'h12345678, 1, 0);
    wr(0, 0);
    cur_req = "R3";
    hd(29'h21, 0, 0);  hd(29'h5A1, 0, 0);  hd(29'h22, 0, 0);  hd(29'h21, 0, 1);
    cur_req = "R2";
    hd((29'h21 << 18) | 29'h5, 1, 0);  hd(29'h21, 1, 0);  hd(29'h300, 0, 0);
    cur_req = "R4";
    hd(29'h080, 0, 0);  hd(29'h080, 0, 1);  hd(29'h12345678, 1, 0);  hd(29'h12345679, 1, 0);
    cur_req = "R5";
    hd(29'h300, 0, 0);  hd(29'h300, 0, 1);  hd(29'h301, 0, 0);
    cur_req = "R6";
    hd(29'h011, 0, 1);  hd(29'h011, 0, 0);  hd(29'h012, 0, 0);
    hd(29'h1A2C0000, 1, 0);  hd(29'h1A2DFFFF, 1, 0);  hd(29'h013, 0, 0);
    cur_req = "R7";
    wr(1, 32'h3E);
    hd(29'h21, 0, 0);
    cur_req = "R8";
    hd(29'h5A1, 0, 0);
    cur_req = "R9";
    hd(29'h0ABCDEF, 1, 0);
    wr(1, 32'h3F);
    hd(29'h21, 0, 0);
    cur_req = "R11";
    wr(8, 32'h55 << 21);  wr(2, 32'h0);  wr(4, 32'h3F);
    hd(29'h21, 0, 0);  hd(29'h080, 0, 0);
    wr(0, 1);  wr(8, 32'h55 << 21);  wr(3, 32'h0);
    hd(29'h21, 0, 0);
    wr(0, 0);  hd(29'h21, 0, 0);  hd(29'h011, 0, 1);
    wr(0, 1);  wr(1, 32'h3E);  wr(8, 32'h55 << 21);  wr(1, 32'h3F);  wr(0, 0);
    hd(29'h55, 0, 0);  hd(29'h21, 0, 0);
    cur_req = "R1";
    hd(29'h55, 0, 0);  hd(29'h300, 0, 0);  idle();  hd(29'h7FF, 0, 0);  idle();
    for (int n = 0; n < 400; n++) begin
      logic [28:0] rid;
      rid = 29'($urandom);
      if (n % 4 == 0) rid[6:0] = 7'h21;
      if (n % 4 == 1) rid[24:18] = 7'h21;
      step(0, 0, 0, ($urandom % 3) != 0, rid, 1'($urandom), 1'($urandom));
    end
    idle();  idle();
    finish_run();
  end

endmodule